// File: doc/BRIEF.md
# Logical Destination Acceptance Arbiter

This block decides which of several processor-local interrupt units take a broadcast interrupt message. Every unit sees the same destination byte. Each unit masks that byte with its destination format register, which marks the bits that count. It then masks the result with its logical destination register. A unit accepts the message if any bit is left set.

In fixed delivery every accepting unit is granted. In lowest-priority delivery the acceptors are reduced to one unit: the one with the smallest priority value, with ties going to the smallest unit index. The grant vector is registered and appears one cycle after the message strobe. When no unit accepts, a no-acceptor flag is raised instead. The per-unit registers are loaded through a simple write port that selects a unit and a register.

Top module: `ldaa_top`

## Requirements
- R1: After reset `grant_valid`, `grant` and `no_accept` are 0. Every format register resets to all ones, every logical destination register to 0 and every priority to 0.
- R2: `grant_valid` is 1 in the cycle that follows a clock edge at which `msg_valid` was sampled 1, and 0 after any edge at which it was sampled 0.
- R3: Unit i accepts when the bitwise AND of `msg_dest`, its format register and its logical destination register is nonzero.
- R4: A unit whose logical destination register is 0 never accepts, whatever the destination.
- R5: With `msg_lowest`=0 (fixed delivery), `grant` equals the set of accepting units, so several bits may be set.
- R6: With `msg_lowest`=1, `grant` has exactly the one acceptor whose priority value is numerically smallest.
- R7: In lowest-priority delivery, acceptors that tie on the smallest priority value resolve to the lowest unit index.
- R8: When no unit accepts a valid message, `no_accept` is 1 and `grant` is 0 in the `grant_valid` cycle. When some unit accepts, `no_accept` is 0.
- R9: A write with `cfg_we`=1 targets unit `cfg_unit`. `cfg_sel` 0 loads the format register, 1 loads the logical destination register, and 2 loads the priority from the low PRIO_W bits of `cfg_data`. `cfg_sel` 3 has no effect. A written value is used by a message sampled at the next clock edge.
- R10: While `grant_valid` is 0, `grant` and `no_accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message strobe |
| msg_dest | input | DEST_W | Broadcast logical destination |
| msg_lowest | input | 1 | 1 = lowest-priority delivery, 0 = fixed |
| cfg_we | input | 1 | Register write enable |
| cfg_unit | input | IDX_W | Target unit index |
| cfg_sel | input | 2 | Register select (0 format, 1 logical destination, 2 priority, 3 none) |
| cfg_data | input | DEST_W | Write data |
| grant_valid | output | 1 | Result valid, one cycle after the message |
| grant | output | NUM_UNITS | Units granted the interrupt |
| no_accept | output | 1 | No unit accepted the message |

## Verification
The assertions assume that inputs hold known values after reset. They also assume that `msg_dest` and `msg_lowest` matter only in cycles where `msg_valid` is 1, so they check those fields only through the strobe that follows. The stimulus changes every input at the falling clock edge and holds it for a whole cycle. It never issues a register write and a message in the same cycle, so each check has exactly one register state to compare against.

// File: rtl/ldaa_pkg.sv
package ldaa_pkg;
   typedef enum logic [1:0] {
      CFG_FMT  = 2'd0,
      CFG_LDR  = 2'd1,
      CFG_PRIO = 2'd2,
      CFG_NONE = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/ldaa_unit.sv
module ldaa_unit
   import ldaa_pkg::*;
#(
   parameter int DEST_W = 8,
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DEST_W-1:0] wr_data,
   input  logic [DEST_W-1:0] dest,
   output logic              accept,
   output logic [PRIO_W-1:0] prio
);
   if (PRIO_W > DEST_W) begin : g_bad_prio
      $error("ldaa_unit: PRIO_W must not exceed DEST_W");
   end

   logic [DEST_W-1:0] fmt_q;
   logic [DEST_W-1:0] ldr_q;
   logic [PRIO_W-1:0] prio_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q  <= '1;
         ldr_q  <= '0;
         prio_q <= '0;
      end else if (wr_en) begin
         case (cfg_sel_e'(wr_sel))
            CFG_FMT:  fmt_q  <= wr_data;
            CFG_LDR:  ldr_q  <= wr_data;
            CFG_PRIO: prio_q <= wr_data[PRIO_W-1:0];
            default:  ;
         endcase
      end
   end

   // The format register is applied first, then the logical destination register.
   logic [DEST_W-1:0] masked;
   assign masked = dest & fmt_q;
   assign accept = |(masked & ldr_q);
   assign prio   = prio_q;
endmodule

// File: rtl/ldaa_pick.sv
module ldaa_pick #(
   parameter int NUM_UNITS = 4,
   parameter int PRIO_W    = 4
) (
   input  logic [NUM_UNITS-1:0]        acc,
   input  logic [NUM_UNITS*PRIO_W-1:0] prio_flat,
   output logic [NUM_UNITS-1:0]        win
);
   logic              found;
   logic [PRIO_W-1:0] best;

   // Ascending scan with a strict compare, so an equal priority later in the
   // scan never displaces an earlier (lower-index) winner.
   always_comb begin
      found = 1'b0;
      best  = '0;
      win   = '0;
      for (int i = 0; i < NUM_UNITS; i++) begin
         if (acc[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
            found  = 1'b1;
            best   = prio_flat[i*PRIO_W +: PRIO_W];
            win    = '0;
            win[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ldaa_top.sv
module ldaa_top
   import ldaa_pkg::*;
#(
   parameter int NUM_UNITS = 4,
   parameter int DEST_W    = 8,
   parameter int PRIO_W    = 4,
   localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 msg_valid,
   input  logic [DEST_W-1:0]    msg_dest,
   input  logic                 msg_lowest,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_unit,
   input  logic [1:0]           cfg_sel,
   input  logic [DEST_W-1:0]    cfg_data,
   output logic                 grant_valid,
   output logic [NUM_UNITS-1:0] grant,
   output logic                 no_accept
);
   if (NUM_UNITS < 2) begin : g_bad_units
      $error("ldaa_top: NUM_UNITS must be at least 2");
   end
   if (DEST_W < 1) begin : g_bad_dest
      $error("ldaa_top: DEST_W must be positive");
   end

   logic [NUM_UNITS-1:0]        acc;
   logic [NUM_UNITS*PRIO_W-1:0] prio_flat;
   logic [NUM_UNITS-1:0]        lp_win;

   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      logic [PRIO_W-1:0] p;
      ldaa_unit #(.DEST_W(DEST_W), .PRIO_W(PRIO_W)) u_unit (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_we && (cfg_unit == IDX_W'(g))),
         .wr_sel  (cfg_sel),
         .wr_data (cfg_data),
         .dest    (msg_dest),
         .accept  (acc[g]),
         .prio    (p)
      );
      assign prio_flat[g*PRIO_W +: PRIO_W] = p;
   end

   ldaa_pick #(.NUM_UNITS(NUM_UNITS), .PRIO_W(PRIO_W)) u_pick (
      .acc       (acc),
      .prio_flat (prio_flat),
      .win       (lp_win)
   );

   logic [NUM_UNITS-1:0] sel_grant;
   assign sel_grant = msg_lowest ? lp_win : acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant       <= '0;
         no_accept   <= 1'b0;
      end else begin
         grant_valid <= msg_valid;
         grant       <= msg_valid ? sel_grant : '0;
         no_accept   <= msg_valid && (acc == '0);
      end
   end
endmodule

// File: rtl/ldaa_chk.sv
module ldaa_chk #(
   parameter int NUM_UNITS = 4,
   parameter int DEST_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 msg_valid,
   input logic [DEST_W-1:0]    msg_dest,
   input logic                 msg_lowest,
   input logic                 grant_valid,
   input logic [NUM_UNITS-1:0] grant,
   input logic                 no_accept
);
   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> grant_valid);
   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> !grant_valid);
   // R6
   single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_lowest) |=> $onehot0(grant));
   // R8
   no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (no_accept == (grant == '0)));
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> ((grant == '0) && !no_accept));
   // R4
   zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && (msg_dest == '0)) |=> no_accept);
endmodule

bind ldaa_top ldaa_chk #(.NUM_UNITS(NUM_UNITS), .DEST_W(DEST_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .msg_valid   (msg_valid),
   .msg_dest    (msg_dest),
   .msg_lowest  (msg_lowest),
   .grant_valid (grant_valid),
   .grant       (grant),
   .no_accept   (no_accept)
);

// File: tb/ldaa_top_test.sv
module ldaa_top_test;
   localparam int N = 4;
   localparam int DW = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         msg_valid = 1'b0;
   logic [DW-1:0] msg_dest = '0;
   logic         msg_lowest = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_unit = '0;
   logic [1:0]   cfg_sel = '0;
   logic [DW-1:0] cfg_data = '0;
   logic         grant_valid;
   logic [N-1:0] grant;
   logic         no_accept;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   ldaa_top #(.NUM_UNITS(N), .DEST_W(DW), .PRIO_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
      .msg_lowest(msg_lowest), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .grant_valid(grant_valid),
      .grant(grant), .no_accept(no_accept));

   // {lowest, dest, expected grant, expected no_accept}
   localparam logic [13:0] VEC [11] = '{
      {1'b0, 8'h01, 4'b0011, 1'b0},  // R3 R5
      {1'b0, 8'h02, 4'b0010, 1'b0},  // R3
      {1'b0, 8'h10, 4'b0100, 1'b0},  // R3 format mask
      {1'b0, 8'h11, 4'b0111, 1'b0},  // R5
      {1'b0, 8'h0C, 4'b0000, 1'b1},  // R8
      {1'b1, 8'h01, 4'b0010, 1'b0},  // R6
      {1'b1, 8'h11, 4'b0010, 1'b0},  // R7
      {1'b1, 8'h10, 4'b0100, 1'b0},  // R6
      {1'b1, 8'h0C, 4'b0000, 1'b1},  // R8
      {1'b0, 8'hFF, 4'b0111, 1'b0},  // R4
      {1'b1, 8'h03, 4'b0010, 1'b0}   // R6
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic wr(input int unit, input int sel, input int data);
      cfg_we = 1'b1; cfg_unit = 2'(unit); cfg_sel = 2'(sel); cfg_data = DW'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input bit lp, input int dest, input int exp_g, input bit exp_n,
                       input string req);
      msg_valid = 1'b1; msg_lowest = lp; msg_dest = DW'(dest);
      @(negedge clk);
      msg_valid = 1'b0;
      chk(grant_valid == 1'b1, {req, " valid"}, int'(grant_valid), 1);
      chk(grant == N'(exp_g), {req, " grant"}, int'(grant), exp_g);
      chk(no_accept == exp_n, {req, " no_accept"}, int'(no_accept), int'(exp_n));
   endtask

   initial begin
      #(8 * 5000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset outputs
      chk(!grant_valid && grant == '0 && !no_accept, "R1 outputs",
          int'({grant_valid, grant, no_accept}), 0);
      // R1 R4 reset registers: logical destination 0 so nobody accepts
      send(1'b0, 8'hFF, 4'b0000, 1'b1, "R1 R4 reset regs");

      // Configuration: u0 ldr01 p3, u1 ldr03 p1, u2 fmtF0 ldr13 p1, u3 left at reset
      wr(0, 1, 8'h01); wr(0, 2, 3);
      wr(1, 1, 8'h03); wr(1, 2, 1);
      wr(2, 0, 8'hF0); wr(2, 1, 8'h13); wr(2, 2, 1);

      for (int i = 0; i < 11; i++) begin
         send(VEC[i][13], int'(VEC[i][12:5]), int'(VEC[i][4:1]), VEC[i][0],
              $sformatf("R3 R5 R6 vec%0d", i));
      end

      // R10 and R2: one-cycle pulse, then quiet
      @(negedge clk);
      chk(!grant_valid && grant == '0 && !no_accept, "R10 R2 idle",
          int'({grant_valid, grant, no_accept}), 0);

      // R9: write used by a message at the very next edge; u3 ldr01 p0
      wr(3, 1, 8'h01);
      send(1'b1, 8'h01, 4'b1000, 1'b0, "R9 next edge");
      // R9: select 3 changes nothing
      wr(3, 3, 8'h00);
      send(1'b1, 8'h01, 4'b1000, 1'b0, "R9 sel3 ignored");
      // R7: u3 p5, u0 p1 ties with u1 p1, lowest index wins
      wr(3, 2, 5); wr(0, 2, 1);
      send(1'b1, 8'h01, 4'b0001, 1'b0, "R7 tie index");
      // R5: fixed mode ignores priority
      send(1'b0, 8'h01, 4'b1011, 1'b0, "R5 fixed all");
      // R4: clearing u3 ldr stops it accepting
      wr(3, 1, 8'h00);
      send(1'b0, 8'h01, 4'b0011, 1'b0, "R4 cleared ldr");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule